// File: doc/BRIEF.md
# Dual Halfword Multiply-Accumulate Unit

This unit takes two 32-bit operands and a 64-bit accumulator, supplied as a high word and a low word. It splits each operand into two signed 16-bit halves and forms two signed 16x16 products. It then adds both products to the accumulator and returns the 64-bit sum as a high word and a low word. A swap control changes how the halves are paired, so that the top half of A meets the bottom half of B, and the bottom half of A meets the top half of B.

The datapath has two register stages. The first stage captures the two products together with the accumulator. The second stage captures the three-way sum. Each accepted input produces exactly one result two cycles later. A new input may be accepted on every cycle. The sum wraps silently modulo 2^64, and the unit produces no flags.

The pipeline has no states in the state-machine sense. Its only control state is two valid bits:

- **Empty**: both valid bits are low.
- **Filling**: stage 1 is valid.
- **Delivering**: the output stage is valid.

Each valid bit follows the bit before it on every clock.

Top module: `dual_mac_top`

## Requirements
- R1: Each operand half is a two's-complement 16-bit number, so 0x8000 counts as -32768 and 0xFFFF counts as -1. The upper half is bits [31:16] and the lower half is bits [15:0].
- R2: With `in_swap` = 0, the two products are a[31:16]*b[31:16] and a[15:0]*b[15:0].
- R3: With `in_swap` = 1, the two products are a[31:16]*b[15:0] and a[15:0]*b[31:16].
- R4: The result is product1 + product2 + the signed 64-bit value {in_acc_hi, in_acc_lo}, reduced modulo 2^64. Overflow is not reported.
- R5: Result bits [63:32] appear on `out_hi` and result bits [31:0] appear on `out_lo`.
- R6: `out_valid` is high exactly two clock edges after the edge that sampled `in_valid` high, and low otherwise. Inputs offered on consecutive cycles each produce one result, in order.
- R7: While `out_valid` is low, `out_hi` and `out_lo` keep the last result they showed.
- R8: A synchronous active-high `rst` clears both valid bits and drives `out_hi` and `out_lo` to zero.
- R9: The extreme case works as follows. When a = b = 0x80008000 (with either swap value) and the accumulator is 0x7FFFFFFF_FFFFFFFF, the sum wraps to 0x80000000_7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operands are valid this cycle |
| in_a | input | 32 | Operand A, two signed halves |
| in_b | input | 32 | Operand B, two signed halves |
| in_swap | input | 1 | Exchange the halves of B before multiplying |
| in_acc_hi | input | 32 | Accumulator bits [63:32] |
| in_acc_lo | input | 32 | Accumulator bits [31:0] |
| out_valid | output | 1 | Result is valid this cycle |
| out_hi | output | 32 | Result bits [63:32] |
| out_lo | output | 32 | Result bits [31:0] |

## Verification
Corrupted internal state shows up at the ports within two cycles of the input that triggers it:

- A stuck or skipped valid bit shifts `out_valid` off its two-cycle slot, or leaves a result missing or duplicated in the scoreboard.
- A stage register loaded on an idle cycle changes `out_hi`/`out_lo` while `out_valid` is low.
- A wrong half pairing or sign extension gives a 64-bit mismatch against the reference on the first operand whose halves differ or are negative.
- A truncated carry gives a mismatch on the wrap case at the accumulator extreme.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int ACC_W  = 2 * WORD_W;
    localparam int PROD_W = 2 * HALF_W;
    localparam int LANES  = 2;
endpackage

// File: rtl/dmac_prod.sv
module dmac_prod #(
    parameter int HW = dmac_pkg::HALF_W,
    parameter int AW = dmac_pkg::ACC_W,
    localparam int WW = 2 * HW,
    localparam int PW = 2 * HW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vld_i,
    input  logic [WW-1:0]   a_i,
    input  logic [WW-1:0]   b_i,
    input  logic            swap_i,
    input  logic [AW-1:0]   acc_i,
    output logic            vld_o,
    output logic [2*PW-1:0] prod_o,
    output logic [AW-1:0]   acc_o
);
    for (genvar i = 0; i < 2; i++) begin : g_lane
        logic signed [HW-1:0] a_half;
        logic signed [HW-1:0] b_half;
        logic signed [PW-1:0] prod_c;
        logic signed [PW-1:0] prod_q;

        assign a_half = a_i[i*HW +: HW];
        assign b_half = swap_i ? b_i[(1-i)*HW +: HW] : b_i[i*HW +: HW];
        assign prod_c = a_half * b_half;

        always_ff @(posedge clk) begin
            if (rst)
                prod_q <= '0;
            else if (vld_i)
                prod_q <= prod_c;
        end

        assign prod_o[i*PW +: PW] = prod_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            acc_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i)
                acc_o <= acc_i;
        end
    end

    // R6
    s1_follow_chk: assert property (@(posedge clk) disable iff (rst) vld_i |=> vld_o);
    // R6
    s1_idle_chk: assert property (@(posedge clk) disable iff (rst) !vld_i |=> !vld_o);
endmodule

// File: rtl/dmac_sum.sv
module dmac_sum #(
    parameter int PW = dmac_pkg::PROD_W,
    parameter int AW = dmac_pkg::ACC_W,
    localparam int EXT = AW - PW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vld_i,
    input  logic [2*PW-1:0] prod_i,
    input  logic [AW-1:0]   acc_i,
    output logic            vld_o,
    output logic [AW-1:0]   sum_o
);
    logic [AW-1:0] p_lo_x;
    logic [AW-1:0] p_hi_x;
    logic [AW-1:0] sum_c;

    assign p_lo_x = {{EXT{prod_i[PW-1]}}, prod_i[PW-1:0]};
    assign p_hi_x = {{EXT{prod_i[2*PW-1]}}, prod_i[2*PW-1:PW]};
    assign sum_c  = p_lo_x + p_hi_x + acc_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            sum_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i)
                sum_o <= sum_c;
        end
    end

    // R6
    out_follow_chk: assert property (@(posedge clk) disable iff (rst) vld_i |=> vld_o);
    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst) !vld_i |=> $stable(sum_o));
endmodule

// File: rtl/dual_mac_top.sv
module dual_mac_top #(
    parameter int HALF_W = dmac_pkg::HALF_W,
    localparam int WW = 2 * HALF_W,
    localparam int AW = 2 * WW,
    localparam int PW = 2 * HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [WW-1:0] in_a,
    input  logic [WW-1:0] in_b,
    input  logic          in_swap,
    input  logic [WW-1:0] in_acc_hi,
    input  logic [WW-1:0] in_acc_lo,
    output logic          out_valid,
    output logic [WW-1:0] out_hi,
    output logic [WW-1:0] out_lo
);
    logic            s1_vld;
    logic [2*PW-1:0] s1_prod;
    logic [AW-1:0]   s1_acc;
    logic [AW-1:0]   sum;

    dmac_prod #(.HW(HALF_W), .AW(AW)) u_prod (
        .clk(clk), .rst(rst), .vld_i(in_valid), .a_i(in_a), .b_i(in_b),
        .swap_i(in_swap), .acc_i({in_acc_hi, in_acc_lo}),
        .vld_o(s1_vld), .prod_o(s1_prod), .acc_o(s1_acc)
    );

    dmac_sum #(.PW(PW), .AW(AW)) u_sum (
        .clk(clk), .rst(rst), .vld_i(s1_vld), .prod_i(s1_prod), .acc_i(s1_acc),
        .vld_o(out_valid), .sum_o(sum)
    );

    assign out_hi = sum[AW-1:WW];
    assign out_lo = sum[WW-1:0];

    // R8
    rst_clear_chk: assert property (@(posedge clk) rst |=> !out_valid && out_hi == '0 && out_lo == '0);
endmodule

// File: tb/sim_dual_mac_top.sv
module sim_dual_mac_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0, in_b = '0, in_acc_hi = '0, in_acc_lo = '0;
    logic        in_swap = 1'b0;
    logic        out_valid;
    logic [31:0] out_hi, out_lo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [63:0] exp_q[$];
    int          due_q[$];
    logic [63:0] last_out = '0;
    logic        monitor_on = 1'b0;

    dual_mac_top u0 (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] model(input logic [31:0] a, b, input logic s,
                                          input logic [63:0] acc);
        longint ah = longint'($signed(a[31:16]));
        longint al = longint'($signed(a[15:0]));
        longint bh = longint'($signed(b[31:16]));
        longint bl = longint'($signed(b[15:0]));
        longint r;
        if (s) r = ah * bl + al * bh + longint'(acc);
        else   r = ah * bh + al * bl + longint'(acc);
        return 64'(r);
    endfunction

    task automatic check(input string req, input logic [63:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, b, input logic s, input logic [63:0] acc);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_swap = s;
        {in_acc_hi, in_acc_lo} = acc;
        exp_q.push_back(model(a, b, s, acc));
        due_q.push_back(cyc + 2);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a = $urandom; in_b = $urandom; in_swap = 1'($urandom);
            {in_acc_hi, in_acc_lo} = {$urandom, $urandom};
        end
    endtask

    // scoreboard monitor: R1-R6 through compared values, R7 on idle cycles
    always @(negedge clk) begin
        if (monitor_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R6 actual=unexpected result expected=none");
                end else begin
                    logic [63:0] e;
                    int d;
                    e = exp_q.pop_front();
                    d = due_q.pop_front();
                    check("R4 R5", {out_hi, out_lo}, e);
                    check("R6 latency", 64'(cyc), 64'(d));
                    last_out = e;
                end
            end else begin
                // R7 hold while idle
                check("R7", {out_hi, out_lo}, last_out);
                if (due_q.size() != 0 && due_q[0] <= cyc) begin
                    checks++; errors++;
                    $display("FAIL R6 actual=no result expected=result due at %0d", due_q[0]);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 valid", 64'(out_valid), 64'd0);
        check("R8 data", {out_hi, out_lo}, 64'd0);
        @(negedge clk); rst = 1'b0;
        monitor_on = 1'b1;

        // R1 sign handling, R2 straight pairing
        drive(32'hFFFF_0002, 32'h0003_8000, 1'b0, 64'd0);
        drive(32'h0005_0007, 32'h000B_000D, 1'b0, 64'd100);
        // R3 swapped pairing
        drive(32'h0005_0007, 32'h000B_000D, 1'b1, 64'd0);
        drive(32'h8000_0001, 32'h0002_7FFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        idle(3);
        // R9 extreme wrap, both swap values
        drive(32'h8000_8000, 32'h8000_8000, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF);
        drive(32'h8000_8000, 32'h8000_8000, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF);
        idle(3);
        check("R9", last_out, 64'h8000_0000_7FFF_FFFF);
        // R4 carry across the word boundary and negative wrap
        drive(32'h7FFF_7FFF, 32'h7FFF_7FFF, 1'b0, 64'h0000_0000_FFFF_FFFF);
        drive(32'h7FFF_8000, 32'h8000_7FFF, 1'b0, 64'h8000_0000_0000_0000);
        idle(2);
        // R6 back-to-back and random gaps
        for (int k = 0; k < 400; k++) begin
            drive($urandom, $urandom, 1'($urandom), {$urandom, $urandom});
            if ($urandom_range(3) == 0) idle($urandom_range(4, 1));
        end
        idle(5);
        check("R6 drained", 64'(exp_q.size()), 64'd0);
        // R8 reset mid-stream clears outputs
        drive(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 64'd7);
        @(negedge clk); in_valid = 1'b0; rst = 1'b1; monitor_on = 1'b0;
        exp_q.delete(); due_q.delete();
        @(negedge clk); @(negedge clk);
        check("R8 valid after reset", 64'(out_valid), 64'd0);
        check("R8 data after reset", {out_hi, out_lo}, 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule